// File: doc/BRIEF.md
# Keyed Watchdog Timer with Alternating Clear

The block counts cycles of a slow watchdog clock. If software does not clear the count before it reaches the selected terminal value, the block issues a reset. The period is a power of two that runs from 2^8 to 2^15 clock cycles and is chosen by a 3-bit ratio select. With a 32.768 kHz clock this gives periods from about 7.8 ms to about 1 s.

Turning the watchdog off takes two conditions at once. A configuration input must request disable, and a 4-bit key register must hold 4'b1010. Any other key value keeps the watchdog running. The key register returns to 4'b1010 on the external reset.

Software clearing has two modes, selected by a configuration bit:
- **Single mode:** one strobe clears the count.
- **Dual mode:** two strobes must be issued in strict alternation, and a repeated strobe is ignored.

A halt strobe also clears the count. When the block is in run mode, a timeout produces a full-device reset pulse. When the block is in sleep or idle, a timeout produces only a partial reset pulse for the program counter and stack. Both cases set a sticky timeout flag.

Top module: `kwdt_top`

## Requirements
- R1: While rst_ni is low, dev_rst_o, part_rst_o and to_flag_o are 0, the count is 0 and the key register is 4'b1010.
- R2: The watchdog is enabled unless cfg_dis_i is 1 and the key register holds 4'b1010. Any other key value, for example 4'b0101, enables it even with cfg_dis_i at 1. The key register loads key_wdata_i on a clock edge where key_we_i is 1.
- R3: After reset with cfg_dis_i at 1 and no key write, the watchdog is disabled and never times out.
- R4: Once enabled, the count starts from 0 and advances by one per clock. A timeout fires 2^(8+ratio_sel_i) cycles after the last clear, and the count then restarts from 0.
- R5: A timeout with sleep_i at 0 raises dev_rst_o for exactly one cycle, one register stage after the terminal count. part_rst_o stays 0.
- R6: to_flag_o goes to 1 with any timeout pulse and stays at 1 until rst_ni is driven low.
- R7: A timeout with sleep_i at 1 raises part_rst_o for exactly one cycle. dev_rst_o stays 0.
- R8: With cfg_dual_i at 0, a clr_i strobe clears the count, and clr1_i and clr2_i have no effect.
- R9: With cfg_dual_i at 1, clr_i has no effect. The first clr1_i or clr2_i after reset clears the count. After that, a strobe of the same kind as the last accepted one is ignored, and only the other kind clears the count.
- R10: A halt_i strobe clears the count while the watchdog is enabled.
- R11: While the watchdog is disabled, the count holds its value, and clr_i, clr1_i, clr2_i and halt_i have no effect. When the watchdog is enabled again, counting resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Watchdog clock |
| rst_ni | input | 1 | External reset, active low, asynchronous |
| cfg_dis_i | input | 1 | Configuration request to disable |
| cfg_dual_i | input | 1 | 1 selects alternating two-strobe clear |
| key_we_i | input | 1 | Key register write enable |
| key_wdata_i | input | 4 | Key register write data |
| ratio_sel_i | input | 3 | Period select, 2^(8+value) cycles |
| clr_i | input | 1 | Single-mode clear strobe |
| clr1_i | input | 1 | Dual-mode first clear strobe |
| clr2_i | input | 1 | Dual-mode second clear strobe |
| halt_i | input | 1 | Halt strobe, clears the count |
| sleep_i | input | 1 | 1 while the device is in sleep or idle |
| dev_rst_o | output | 1 | Full-device reset pulse |
| part_rst_o | output | 1 | Program counter and stack reset pulse |
| to_flag_o | output | 1 | Sticky timeout flag |

## Verification
An accepted clear or a halt strobe takes effect at the clock edge that samples it. The matching reset pulse is due exactly 2^(8+ratio_sel_i) edges later. A key write changes the enable state from the edge after the write, so the held count of a disabled interval moves the due edge by that amount. The scoreboard records the edge index of every effective stimulus and queues the pulse it predicts. The monitor compares each pulse against the queue by edge index and by kind at the falling clock edge. Any pulse that arrives with nothing queued is counted as a failure, which is how ignored strobes and the disabled state are checked.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam logic [3:0] KEY_OFF = 4'b1010;

  typedef enum logic [1:0] {
    LAST_NONE,
    LAST_ONE,
    LAST_TWO
  } clr_last_e;
endpackage

// File: rtl/kwdt_key.sv
module kwdt_key #(
  parameter int KEY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_dis_i,
  input  logic             we_i,
  input  logic [KEY_W-1:0] wdata_i,
  output logic             en_o
);
  import kwdt_pkg::*;

  logic [KEY_W-1:0] key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   key_q <= KEY_W'(KEY_OFF);
    else if (we_i) key_q <= wdata_i;
  end

  // both conditions must agree to switch off
  assign en_o = !(cfg_dis_i && (key_q == KEY_W'(KEY_OFF)));
endmodule

// File: rtl/kwdt_clr.sv
module kwdt_clr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic dual_i,
  input  logic clr_i,
  input  logic clr1_i,
  input  logic clr2_i,
  input  logic halt_i,
  output logic clear_o
);
  import kwdt_pkg::*;

  clr_last_e last_q;
  logic      acc1, acc2;

  always_comb begin
    acc1 = en_i && dual_i && clr1_i && (last_q != LAST_ONE);
    acc2 = en_i && dual_i && clr2_i && !acc1 && (last_q != LAST_TWO);
  end

  assign clear_o = en_i && (halt_i || (!dual_i && clr_i) || acc1 || acc2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   last_q <= LAST_NONE;
    else if (acc1) last_q <= LAST_ONE;
    else if (acc2) last_q <= LAST_TWO;
  end
endmodule

// File: rtl/kwdt_cnt.sv
module kwdt_cnt #(
  parameter int CNT_W   = 15,
  parameter int MIN_EXP = 8,
  parameter int SEL_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clear_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam int STEPS = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;

  always_comb begin
    term = '0;
    for (int i = 0; i < STEPS; i++) begin
      if (sel_i == SEL_W'(i)) term = CNT_W'((64'd1 << (MIN_EXP + i)) - 64'd1);
    end
  end

  assign wrap_o = en_i && !clear_i && (cnt_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (en_i)    cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
  parameter int CNT_W   = 15,
  parameter int MIN_EXP = 8,
  parameter int SEL_W   = 3,
  parameter int KEY_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_dis_i,
  input  logic             cfg_dual_i,
  input  logic             key_we_i,
  input  logic [KEY_W-1:0] key_wdata_i,
  input  logic [SEL_W-1:0] ratio_sel_i,
  input  logic             clr_i,
  input  logic             clr1_i,
  input  logic             clr2_i,
  input  logic             halt_i,
  input  logic             sleep_i,
  output logic             dev_rst_o,
  output logic             part_rst_o,
  output logic             to_flag_o
);
  logic             wdt_en;
  logic             clear;
  logic             wrap;
  logic [CNT_W-1:0] cnt_q;
  logic             dev_q, part_q, flag_q;

  kwdt_key #(.KEY_W(KEY_W)) u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_dis_i(cfg_dis_i),
    .we_i     (key_we_i),
    .wdata_i  (key_wdata_i),
    .en_o     (wdt_en)
  );

  kwdt_clr u_clr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (wdt_en),
    .dual_i (cfg_dual_i),
    .clr_i  (clr_i),
    .clr1_i (clr1_i),
    .clr2_i (clr2_i),
    .halt_i (halt_i),
    .clear_o(clear)
  );

  kwdt_cnt #(.CNT_W(CNT_W), .MIN_EXP(MIN_EXP), .SEL_W(SEL_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (wdt_en),
    .clear_i(clear),
    .sel_i  (ratio_sel_i),
    .cnt_o  (cnt_q),
    .wrap_o (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_q  <= 1'b0;
      part_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      dev_q  <= wrap && !sleep_i;
      part_q <= wrap && sleep_i;
      if (wrap) flag_q <= 1'b1;
    end
  end

  assign dev_rst_o  = dev_q;
  assign part_rst_o = part_q;
  assign to_flag_o  = flag_q;
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sleep_i,
  input logic             dev_rst_o,
  input logic             part_rst_o,
  input logic             to_flag_o,
  input logic             wdt_en,
  input logic [CNT_W-1:0] cnt
);
  p_dev_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_o |=> !dev_rst_o);

  p_part_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    part_rst_o |=> !part_rst_o);

  p_part_sleep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    part_rst_o |-> $past(sleep_i));

  p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dev_rst_o && part_rst_o));

  p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_flag_o |=> to_flag_o);

  p_flag_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_rst_o || part_rst_o) |-> to_flag_o);

  p_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_rst_o || part_rst_o) |-> (cnt == '0));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdt_en |=> (cnt == $past(cnt)));
endmodule

bind kwdt_top kwdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sleep_i   (sleep_i),
  .dev_rst_o (dev_rst_o),
  .part_rst_o(part_rst_o),
  .to_flag_o (to_flag_o),
  .wdt_en    (wdt_en),
  .cnt       (cnt_q)
);

// File: tb/kwdt_top_test.sv
module kwdt_top_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_dis_i = 1'b0, cfg_dual_i = 1'b0;
  logic       key_we_i = 1'b0;
  logic [3:0] key_wdata_i = 4'h0;
  logic [2:0] ratio_sel_i = 3'd0;
  logic       clr_i = 1'b0, clr1_i = 1'b0, clr2_i = 1'b0, halt_i = 1'b0, sleep_i = 1'b0;
  logic       dev_rst_o, part_rst_o, to_flag_o;

  kwdt_top uut (.*);

  always #4 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  typedef struct { int at; bit part; string req; } exp_t;
  exp_t q[$];
  int nchk = 0, nerr = 0, last_edge = 0, rel = 0;
  bit done = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    {clr_i, clr1_i, clr2_i, halt_i, key_we_i} = '0;
    tick(2);
    rst_ni = 1'b1;
    rel = cyc;
  endtask

  // which: 0 clr, 1 clr1, 2 clr2, 3 halt
  task automatic strobe(int which);
    case (which)
      0: clr_i = 1'b1;
      1: clr1_i = 1'b1;
      2: clr2_i = 1'b1;
      default: halt_i = 1'b1;
    endcase
    last_edge = cyc + 1;
    tick(1);
    {clr_i, clr1_i, clr2_i, halt_i} = '0;
  endtask

  task automatic write_key(logic [3:0] v);
    key_we_i = 1'b1;
    key_wdata_i = v;
    last_edge = cyc + 1;
    tick(1);
    key_we_i = 1'b0;
  endtask

  task automatic expect_ev(int at, bit part, string req);
    exp_t e;
    e.at = at; e.part = part; e.req = req;
    q.push_back(e);
  endtask

  task automatic drained(string req);
    check(q.size() == 0, req, "pending pulses", q.size(), 0);
    q.delete();
  endtask

  // monitor: compares each pulse against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && (dev_rst_o || part_rst_o)) begin
      if (q.size() == 0) begin
        check(1'b0, "R5", "unexpected pulse at cycle", cyc, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(cyc == e.at, e.req, "pulse cycle", cyc, e.at);
        check(part_rst_o == e.part, e.req, "partial kind", int'(part_rst_o), int'(e.part));
        check(dev_rst_o == !e.part, e.req, "device kind", int'(dev_rst_o), int'(!e.part));
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int d_e, e_e;
    tick(1);
    // R1 reset state
    check({dev_rst_o, part_rst_o, to_flag_o} == 3'b000, "R1", "outputs in reset", {dev_rst_o, part_rst_o, to_flag_o}, 0);

    // R5 run-mode timeout, R6 flag, R2 enabled with key 1010 and cfg enable
    do_reset();
    expect_ev(rel + 256, 1'b0, "R5");
    tick(260);
    drained("R5");
    check(to_flag_o == 1'b1, "R6", "flag after timeout", to_flag_o, 1);
    tick(3);
    check(to_flag_o == 1'b1, "R6", "flag still set", to_flag_o, 1);
    do_reset();
    check(to_flag_o == 1'b0, "R6", "flag cleared by reset", to_flag_o, 0);

    // R7 sleep timeout
    sleep_i = 1'b1;
    expect_ev(rel + 256, 1'b1, "R7");
    tick(260);
    drained("R7");
    check(to_flag_o == 1'b1, "R7", "flag after partial", to_flag_o, 1);
    sleep_i = 1'b0;

    // R8 single mode: clr1/clr2 ignored, clr clears
    do_reset();
    tick(50);  strobe(1);
    tick(50);  strobe(2);
    tick(100); strobe(0);
    expect_ev(last_edge + 256, 1'b0, "R8");
    tick(260);
    drained("R8");

    // R9 dual mode alternation
    cfg_dual_i = 1'b1;
    do_reset();
    tick(50);  strobe(1);
    tick(100); strobe(1);
    tick(50);  strobe(2);
    e_e = last_edge;
    tick(100); strobe(2);
    tick(50);  strobe(0);
    expect_ev(e_e + 256, 1'b0, "R9");
    tick(170);
    drained("R9");
    // R9 first strobe may be clr2
    do_reset();
    tick(100); strobe(2);
    expect_ev(last_edge + 256, 1'b0, "R9");
    tick(260);
    drained("R9");
    cfg_dual_i = 1'b0;

    // R10 halt clears
    do_reset();
    tick(150); strobe(3);
    expect_ev(last_edge + 256, 1'b0, "R10");
    tick(260);
    drained("R10");

    // R4 ratio select
    ratio_sel_i = 3'd1;
    do_reset();
    expect_ev(rel + 512, 1'b0, "R4");
    tick(515);
    drained("R4");
    ratio_sel_i = 3'd7;
    do_reset();
    expect_ev(rel + 32768, 1'b0, "R4");
    tick(32771);
    drained("R4");
    ratio_sel_i = 3'd0;

    // R3 disabled after reset when cfg requests disable
    cfg_dis_i = 1'b1;
    do_reset();
    tick(600);
    drained("R3");
    check(to_flag_o == 1'b0, "R3", "flag while disabled", to_flag_o, 0);

    // R2 other key enables; R11 hold and ignored clears while disabled
    write_key(4'b0101);
    e_e = last_edge;
    tick(99);
    write_key(4'b1010);
    d_e = last_edge;
    tick(20); strobe(0);
    tick(5);  strobe(3);
    tick(20);
    write_key(4'b0101);
    expect_ev(last_edge + 256 - (d_e - e_e), 1'b0, "R11");
    tick(260);
    drained("R11");
    check(to_flag_o == 1'b1, "R2", "key 0101 enables", to_flag_o, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule